// File: doc/BRIEF.md
# UART Interrupt Enable and Identification Register

This block holds the per-source interrupt enables of a simple UART and reports which interrupt sources are pending. It sits on an 8-bit register bus with an address, a read strobe, a write strobe, write data and read data. Three event inputs come from the UART core: a line-status error, receive data ready, and transmit holding register empty.

A rising edge on an event input sets that source's pending flag, but only while the source's enable bit is 1. The pending flags form a bitmap, so several can be set at once. Bit position gives the service priority: line-status error in bit 2 is serviced first, then receive data in bit 1, then transmit empty in bit 0. Each flag is cleared by its own bus access. A line-status read clears bit 2. A receive-buffer read clears bit 1. A read of this register or a write to the transmit holding register clears bit 0. The single interrupt output is high while any flag is set.

Top module: `uart_irq_reg`

## Requirements
- R1: After reset, every enable and every pending flag is 0, a read at the register address (2) returns 0x00, and `irq` is 0.
- R2: A write at address 2 stores the enables as follows: bit 6 enables line-status error, bit 5 enables transmit empty, and bit 4 enables receive data. A read returns them in the same positions, and bits 7 and 3 always read 0.
- R3: Write data bits 2:0 at address 2 are ignored, and the pending flags keep their values.
- R4: A pending flag is set one clock after a rising edge of its event input, and only if its enable was already 1 in that cycle. An event that stays high does not set the flag again after it has been cleared. An event while the source is disabled sets nothing.
- R5: Read bits 2:0 form a bitmap. Bit 2 is line-status error, bit 1 is receive data ready, and bit 0 is transmit empty. Any combination of the three can be set at once.
- R6: A read at the line-status address (5) clears pending bit 2 at the next clock.
- R7: A read at the data address (0) clears pending bit 1 at the next clock.
- R8: Either a read at address 2 or a write at the data address (0) clears pending bit 0 at the next clock. A read at address 2 returns the flag values from before that clear.
- R9: If a set edge and a clearing access fall in the same cycle, the flag ends up set.
- R10: A write at address 2 that makes an enable 0 also clears that source's pending flag, even if a set edge arrives in the same cycle.
- R11: `irq` is the OR of the three pending flags, so it stays high until the last flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Register address |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `rd_en` is high at address 2, otherwise 0 |
| ev_lsr_err | input | 1 | Line-status error event level |
| ev_rx_ready | input | 1 | Receive data ready event level |
| ev_tx_empty | input | 1 | Transmit holding empty event level |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties assume that `rd_en` and `wr_en` are never high in the same cycle. They also assume that each access lasts exactly one cycle, so a held strobe does not count as repeated clears. The bench drives every strobe for one clock, starting at a falling edge, and never raises both strobes together. Event inputs change only at falling edges. Between sweep points the bench returns each event to 0 for at least one clock, so every stimulus gives the block a clean rising edge.

// File: rtl/uart_irq_reg.sv
module uart_irq_reg #(
  parameter int ADDR_W    = 3,
  parameter int IE_ADDR   = 2,
  parameter int DATA_ADDR = 0,
  parameter int LSR_ADDR  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              ev_lsr_err,
  input  logic              ev_rx_ready,
  input  logic              ev_tx_empty,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_IE   = IE_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_DATA = DATA_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_LSR  = LSR_ADDR[ADDR_W-1:0];

  logic [2:0] en, pend, ev_q;
  wire  [2:0] ev = {ev_lsr_err, ev_rx_ready, ev_tx_empty};

  wire ie_rd  = rd_en && addr == A_IE;
  wire ie_wr  = wr_en && addr == A_IE;
  wire lsr_rd = rd_en && addr == A_LSR;
  wire rbr_rd = rd_en && addr == A_DATA;
  wire thr_wr = wr_en && addr == A_DATA;

  // internal order: [2] line status, [1] receive, [0] transmit
  wire [2:0] en_nxt = ie_wr ? {wdata[6], wdata[4], wdata[5]} : en;
  wire [2:0] rise   = ev & ~ev_q;
  wire [2:0] clr    = {lsr_rd, rbr_rd, ie_rd | thr_wr};
  wire       unused_wbits = ^{wdata[7], wdata[3:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en   <= '0;
      pend <= '0;
      ev_q <= '0;
    end else begin
      en   <= en_nxt;
      pend <= ((pend & ~clr) | (rise & en)) & en_nxt;
      ev_q <= ev;
    end

  assign rdata = ie_rd ? {1'b0, en[2], en[0], en[1], 1'b0, pend} : 8'h00;
  assign irq   = |pend;

  AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~en) == 3'b000);                                               // R10
  AST_SET_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend)) & ~$past(ev)) == 3'b000);                        // R4
  AST_LSR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_LSR && !ev_lsr_err) |=> !pend[2]);                  // R6
  AST_RBR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_DATA && !ev_rx_ready) |=> !pend[1]);                // R7
  AST_THRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (((rd_en && addr == A_IE) || (wr_en && addr == A_DATA)) && !ev_tx_empty)
      |=> !pend[0]);                                                        // R8
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rd_en && !wr_en) |=> irq);                                     // R11
  AST_IE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_IE) |=> (en == {$past(wdata[6]), $past(wdata[4]), $past(wdata[5])})); // R2

endmodule

// File: tb/uart_irq_reg_test.sv
module uart_irq_reg_test;
  localparam int PERIOD = 10;
  localparam logic [2:0] A_IE = 3'd2, A_DATA = 3'd0, A_LSR = 3'd5;

  logic clk = 0, rst_n = 0, rd_en = 0, wr_en = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [2:0] ev = '0;
  logic irq;
  int checks = 0, fails = 0;

  uart_irq_reg uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .ev_lsr_err(ev[2]), .ev_rx_ready(ev[1]),
    .ev_tx_empty(ev[0]), .irq(irq)
  );

  always #(PERIOD/2) clk = ~clk;

  initial begin
    #(PERIOD*200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic logic [7:0] ie_byte(input logic [2:0] e, input logic [2:0] p);
    return {1'b0, e[2], e[0], e[1], 1'b0, p};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd_en = 1; #1 d = rdata;
    cycle; rd_en = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    addr = a; wdata = v; wr_en = 1;
    cycle; wr_en = 0;
  endtask

  task automatic pulse(input logic [2:0] m);
    ev = ev | m; cycle; ev = ev & ~m; cycle;
  endtask

  logic [7:0] d;
  logic [2:0] exp;

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 irq in reset", irq, 0);
    rst_n = 1; @(negedge clk);
    rd(A_IE, d); check("R1 reset read", d, 8'h00);
    check("R1 irq after reset", irq, 0);

    for (int e = 0; e < 8; e++)
      for (int m = 0; m < 8; m++) begin
        wr(A_IE, 8'h00);
        wr(A_IE, ie_byte(e[2:0], 3'b000));
        pulse(m[2:0]);
        exp = m[2:0] & e[2:0];
        check("R4 R11 irq after events", irq, |exp);
        wr(A_IE, ie_byte(e[2:0], 3'b000) | 8'h8F);
        rd(A_IE, d);
        check("R2 R3 R5 readback", d, ie_byte(e[2:0], exp));
        check("R8 irq after ie read", irq, |(exp & 3'b110));
      end

    wr(A_IE, 8'h70);
    pulse(3'b111);
    rd(A_LSR, d);
    rd(A_IE, d); check("R6 lsr read clears bit2", d, ie_byte(3'b111, 3'b011));
    pulse(3'b111);
    rd(A_DATA, d);
    rd(A_IE, d); check("R7 rbr read clears bit1", d, ie_byte(3'b111, 3'b101));
    pulse(3'b111);
    wr(A_DATA, 8'h55);
    rd(A_IE, d); check("R8 thr write clears bit0", d, ie_byte(3'b111, 3'b110));
    rd(A_LSR, d); rd(A_DATA, d);
    pulse(3'b001);
    rd(A_IE, d); check("R8 first read shows bit0", d, ie_byte(3'b111, 3'b001));
    rd(A_IE, d); check("R8 second read cleared", d, ie_byte(3'b111, 3'b000));

    ev = 3'b100; cycle;
    rd(A_LSR, d); cycle;
    check("R4 held level no reset", irq, 0);
    ev = 3'b000; cycle;

    addr = A_IE; rd_en = 1; ev = 3'b001; #1 d = rdata;
    check("R9 read value before set", d, ie_byte(3'b111, 3'b000));
    cycle; rd_en = 0; ev = 3'b000;
    check("R9 set wins over clear", irq, 1);
    rd(A_IE, d); check("R9 flag visible", d, ie_byte(3'b111, 3'b001));

    pulse(3'b100);
    wr(A_IE, 8'h30);
    check("R10 disable clears flag", irq, 0);
    wr(A_IE, 8'h70);
    addr = A_IE; wdata = 8'h30; wr_en = 1; ev = 3'b100;
    cycle; wr_en = 0; ev = 3'b000;
    check("R10 disable beats set", irq, 0);

    wr(A_IE, 8'h70);
    pulse(3'b101);
    rd(A_LSR, d);
    check("R11 irq held with bit0", irq, 1);
    wr(A_DATA, 8'h00);
    check("R11 irq drops when all clear", irq, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule